// File: doc/BRIEF.md
# Branch, Call and Trap Sequencer

This block resolves control-transfer instructions for a small processor with 24-bit addresses. For each accepted instruction it produces the next program counter, the next stack pointer, the resulting status byte and the resulting r0 value. It also issues the memory traffic that saves or restores return state. The instructions it handles are conditional relative jumps, relative and absolute calls, subroutine return, software traps with and without a level update, trap return, debug break and debug return. Instruction decode supplies a 4-bit kind code, a delayed-slot flag, a width flag for the long forms, the zero flag and a raw operand field. The register file supplies the operand register, pc, sp, status, r0 and the trap table base.

Three valid/ready channels carry the data. The instruction channel is accepted only while the sequencer is idle. After that, `in_ready` stays low until the result has been taken. Each memory request on the memory channel is held with stable address, data and direction until `mem_ready` is high. A read's data is sampled in the cycle where `mem_valid` and `mem_ready` are both high. Writes and reads that belong to one instruction are issued one at a time in a fixed order. The result channel holds its values stable until `out_ready` is high. After that the block is idle again in the following cycle.

The status word is 8 bits wide. A saved state word is 32 bits, with status in bits 31:24 and the address in bits 23:0. The interrupt level occupies status bits 7:5. The debug save area base and the debug entry address are parameters, 0xFFF800 and 0xFFFC00 by default. All address arithmetic wraps modulo 2^24.

Top module: `xfer_seq`

## Requirements
- R1: `in_ready` is high only while idle. After an instruction is accepted, `in_ready` is low until the result is taken, and `out_valid` with `out_pc`/`out_sp` stays stable while `out_ready` is low. The cycle after the result is taken, `in_ready` is high again.
- R2: Short jumps are kind 0 (taken when zero=1) and kind 1 (taken when zero=0). When taken, the next pc is pc+2+{sign-extended operand[6:0],0}; otherwise it is pc+2. No memory access is made and sp is unchanged.
- R3: Long jumps are kind 2 (zero=1) and kind 3 (zero=0). When taken, the next pc is pc+2 plus a displacement; otherwise it is pc+2. The displacement is sign-extended operand[19:0] when wide=0 and operand[23:0] when wide=1.
- R4: Relative calls target a different address per kind:
  - kind 4: pc+2+operand.
  - kind 5: pc+2+{sign-extended operand[9:0],0}.
  - kind 6: pc+2 plus the R3 displacement.
- R5: Absolute calls target a different address per kind:
  - kind 7: the operand.
  - kind 8: zero-extended operand[6:0].
  - kind 9: zero-extended operand[19:0] when wide=0, or operand[23:0] when wide=1.
- R6: Every call (kinds 4 to 9) makes exactly one write at address sp-4 with data {8'h00, ret}, and the next sp is sp-4. ret is pc+2 when delay=0 and pc+4 when delay=1.
- R7: Return (kind 10) makes one read at sp. The next pc is the read data bits 23:0, the next sp is sp+4, and status is unchanged.
- R8: Traps are kind 11 and kind 12.
  - The first access writes {status, pc+2} at sp-4.
  - The second access reads at trap_base + operand[4:0]×4.
  - The next pc is the read data bits 23:0 and the next sp is sp-4.
  - Kind 12 also sets status bits 7:5 to operand[7:5]; the other status bits are kept.
- R9: Trap return (kind 13) makes one read at sp. Status comes from read bits 31:24, pc from bits 23:0, and the next sp is sp+4.
- R10: Debug break (kind 14) makes two writes. It writes {status, pc+2} at the debug base, then {8'h00, r0} at the debug base+4. The next pc is the debug entry address; sp and status are unchanged.
- R11: Debug return (kind 15) makes two reads. It reads at the debug base first, giving status and pc. It then reads at the debug base+4, giving r0 from bits 23:0. sp is unchanged.
- R12: While `mem_ready` is low, a request keeps `mem_valid`, address, data and direction stable. Stalls of any length change neither the access sequence nor the result.
- R13: pc and sp arithmetic wraps modulo 2^24.
- R14: After reset, `in_ready` is high and `out_valid` and `mem_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction accepted |
| in_kind | input | 4 | Control-transfer kind code (see requirements) |
| in_delay | input | 1 | Delayed-slot flag, selects return address pc+4 |
| in_wide | input | 1 | Long forms use 24-bit field instead of 20-bit |
| in_zero | input | 1 | Zero flag |
| in_operand | input | 24 | Immediate field or operand register value |
| in_pc | input | 24 | Current pc |
| in_sp | input | 24 | Current sp |
| in_psr | input | 8 | Current status byte |
| in_r0 | input | 24 | Current r0 |
| in_ttbr | input | 24 | Trap table base |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 24 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid on acceptance |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result taken |
| out_pc | output | 24 | Next pc |
| out_sp | output | 24 | Next sp |
| out_psr | output | 8 | Resulting status byte |
| out_r0 | output | 24 | Resulting r0 |

## Verification
The bench sweeps every kind code across both delay and zero values, four operand/pc/sp patterns and three stall lengths. It targets the following corner cases:
- Operand sign bits at bit 6, 9 and 19: a design that extends from the wrong bit jumps to an address off by a large power of two.
- The delayed flag: a design that ignores it pushes pc+2 where pc+4 belongs.
- pc at 0xFFFFFE and sp at 0x000002 or 0xFFFFFC: a design that carries past bit 23 or mis-sizes the adder produces wrong wrapped addresses.
- The order of two-access sequences and stalled requests with a held result: a design that swaps the accesses, drops a stalled access or changes outputs under back-pressure shows a wrong address, a wrong access count or an output that moved.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

  typedef enum logic [3:0] {
    K_JEQ_S    = 4'd0,
    K_JNE_S    = 4'd1,
    K_JEQ_L    = 4'd2,
    K_JNE_L    = 4'd3,
    K_CALL_REG = 4'd4,
    K_CALL_S   = 4'd5,
    K_CALL_L   = 4'd6,
    K_CALLA_R  = 4'd7,
    K_CALLA_I7 = 4'd8,
    K_CALLA_L  = 4'd9,
    K_RET      = 4'd10,
    K_TRAP     = 4'd11,
    K_TRAPL    = 4'd12,
    K_RETI     = 4'd13,
    K_DBRK     = 4'd14,
    K_DRET     = 4'd15
  } xfer_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC0 = 2'd1,
    ST_ACC1 = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  function automatic logic [1:0] access_count(input xfer_kind_e k);
    logic [1:0] n;
    case (k)
      K_CALL_REG, K_CALL_S, K_CALL_L,
      K_CALLA_R, K_CALLA_I7, K_CALLA_L,
      K_RET, K_RETI:                      n = 2'd1;
      K_TRAP, K_TRAPL, K_DBRK, K_DRET:    n = 2'd2;
      default:                            n = 2'd0;
    endcase
    return n;
  endfunction

  function automatic logic is_call(input xfer_kind_e k);
    return (k == K_CALL_REG) || (k == K_CALL_S) || (k == K_CALL_L) ||
           (k == K_CALLA_R) || (k == K_CALLA_I7) || (k == K_CALLA_L);
  endfunction

endpackage

// File: rtl/xfer_target.sv
module xfer_target
  import xfer_seq_pkg::*;
#(
  parameter int AW = 24
)(
  input  xfer_kind_e     kind,
  input  logic           delay,
  input  logic           wide,
  input  logic           zero,
  input  logic [AW-1:0]  operand,
  input  logic [AW-1:0]  pc,
  output logic [AW-1:0]  branch_pc,
  output logic [AW-1:0]  ret_addr
);
  localparam logic [AW-1:0] TWO  = AW'(2);
  localparam logic [AW-1:0] FOUR = AW'(4);

  logic [AW-1:0] pc2;
  logic [AW-1:0] disp_s7;
  logic [AW-1:0] disp_s10;
  logic [AW-1:0] disp_long;
  logic [AW-1:0] abs_i7;
  logic [AW-1:0] abs_long;
  logic          take_eq;
  logic          take_ne;

  assign pc2      = pc + TWO;
  assign disp_s7  = {{(AW-8){operand[6]}}, operand[6:0], 1'b0};
  assign disp_s10 = {{(AW-11){operand[9]}}, operand[9:0], 1'b0};
  assign abs_i7   = {{(AW-7){1'b0}}, operand[6:0]};
  assign take_eq  = zero;
  assign take_ne  = ~zero;

  // the 20-bit field is sign-extended for relative use, zero-extended for absolute use
  assign disp_long = wide ? operand : {{(AW-20){operand[19]}}, operand[19:0]};
  assign abs_long  = wide ? operand : {{(AW-20){1'b0}}, operand[19:0]};

  assign ret_addr = delay ? (pc + FOUR) : pc2;

  always_comb begin
    branch_pc = pc2;
    case (kind)
      K_JEQ_S:    if (take_eq) branch_pc = pc2 + disp_s7;
      K_JNE_S:    if (take_ne) branch_pc = pc2 + disp_s7;
      K_JEQ_L:    if (take_eq) branch_pc = pc2 + disp_long;
      K_JNE_L:    if (take_ne) branch_pc = pc2 + disp_long;
      K_CALL_REG: branch_pc = pc2 + operand;
      K_CALL_S:   branch_pc = pc2 + disp_s10;
      K_CALL_L:   branch_pc = pc2 + disp_long;
      K_CALLA_R:  branch_pc = operand;
      K_CALLA_I7: branch_pc = abs_i7;
      K_CALLA_L:  branch_pc = abs_long;
      default:    branch_pc = pc2;
    endcase
  end

endmodule

// File: rtl/xfer_plan.sv
module xfer_plan
  import xfer_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int PSRW = 8,
  parameter logic [AW-1:0] DBG_BASE = AW'(24'hFFF800),
  localparam int DW = PSRW + AW
)(
  input  xfer_kind_e       kind,
  input  logic             step,
  input  logic [AW-1:0]    sp,
  input  logic [AW-1:0]    pc,
  input  logic [PSRW-1:0]  psr,
  input  logic [AW-1:0]    r0,
  input  logic [AW-1:0]    ttbr,
  input  logic [AW-1:0]    ret_addr,
  input  logic [4:0]       imm5,
  output logic             acc_write,
  output logic [AW-1:0]    acc_addr,
  output logic [DW-1:0]    acc_wdata
);
  localparam logic [AW-1:0] TWO  = AW'(2);
  localparam logic [AW-1:0] FOUR = AW'(4);

  logic [AW-1:0] push_addr;
  logic [AW-1:0] vec_addr;
  logic [DW-1:0] state_word;
  logic [DW-1:0] call_word;
  logic [DW-1:0] r0_word;

  assign push_addr  = sp - FOUR;
  assign vec_addr   = ttbr + {{(AW-7){1'b0}}, imm5, 2'b00};
  assign state_word = {psr, pc + TWO};
  assign call_word  = {{PSRW{1'b0}}, ret_addr};
  assign r0_word    = {{PSRW{1'b0}}, r0};

  always_comb begin
    acc_write = 1'b0;
    acc_addr  = sp;
    acc_wdata = '0;
    case (kind)
      K_CALL_REG, K_CALL_S, K_CALL_L,
      K_CALLA_R, K_CALLA_I7, K_CALLA_L: begin
        acc_write = 1'b1;
        acc_addr  = push_addr;
        acc_wdata = call_word;
      end
      K_RET, K_RETI: begin
        acc_addr = sp;
      end
      K_TRAP, K_TRAPL: begin
        if (!step) begin
          acc_write = 1'b1;
          acc_addr  = push_addr;
          acc_wdata = state_word;
        end else begin
          acc_addr  = vec_addr;
        end
      end
      K_DBRK: begin
        acc_write = 1'b1;
        acc_addr  = step ? (DBG_BASE + FOUR) : DBG_BASE;
        acc_wdata = step ? r0_word : state_word;
      end
      K_DRET: begin
        acc_addr = step ? (DBG_BASE + FOUR) : DBG_BASE;
      end
      default: begin
        acc_addr = sp;
      end
    endcase
  end

endmodule

// File: rtl/xfer_result.sv
module xfer_result
  import xfer_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int PSRW = 8,
  parameter int IL_LSB = 5,
  parameter int ILW = 3,
  parameter logic [AW-1:0] DBG_VEC = AW'(24'hFFFC00),
  localparam int DW = PSRW + AW
)(
  input  xfer_kind_e       kind,
  input  logic [AW-1:0]    branch_pc,
  input  logic [AW-1:0]    sp,
  input  logic [PSRW-1:0]  psr,
  input  logic [AW-1:0]    r0,
  input  logic [ILW-1:0]   new_level,
  input  logic [DW-1:0]    word0,
  input  logic [AW-1:0]    word1_lo,
  output logic [AW-1:0]    nxt_pc,
  output logic [AW-1:0]    nxt_sp,
  output logic [PSRW-1:0]  nxt_psr,
  output logic [AW-1:0]    nxt_r0
);
  localparam logic [AW-1:0] FOUR = AW'(4);

  always_comb begin
    nxt_pc  = branch_pc;
    nxt_sp  = sp;
    nxt_psr = psr;
    nxt_r0  = r0;
    case (kind)
      K_CALL_REG, K_CALL_S, K_CALL_L,
      K_CALLA_R, K_CALLA_I7, K_CALLA_L: begin
        nxt_sp = sp - FOUR;
      end
      K_RET: begin
        nxt_pc = word0[AW-1:0];
        nxt_sp = sp + FOUR;
      end
      K_TRAP: begin
        nxt_pc = word1_lo;
        nxt_sp = sp - FOUR;
      end
      K_TRAPL: begin
        nxt_pc = word1_lo;
        nxt_sp = sp - FOUR;
        nxt_psr[IL_LSB +: ILW] = new_level;
      end
      K_RETI: begin
        nxt_psr = word0[DW-1:AW];
        nxt_pc  = word0[AW-1:0];
        nxt_sp  = sp + FOUR;
      end
      K_DBRK: begin
        nxt_pc = DBG_VEC;
      end
      K_DRET: begin
        nxt_psr = word0[DW-1:AW];
        nxt_pc  = word0[AW-1:0];
        nxt_r0  = word1_lo;
      end
      default: begin
        nxt_pc = branch_pc;
      end
    endcase
  end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int PSRW = 8,
  parameter int IL_LSB = 5,
  parameter int ILW = 3,
  parameter logic [AW-1:0] DBG_BASE = AW'(24'hFFF800),
  parameter logic [AW-1:0] DBG_VEC  = AW'(24'hFFFC00),
  localparam int DW = PSRW + AW
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_kind,
  input  logic             in_delay,
  input  logic             in_wide,
  input  logic             in_zero,
  input  logic [AW-1:0]    in_operand,
  input  logic [AW-1:0]    in_pc,
  input  logic [AW-1:0]    in_sp,
  input  logic [PSRW-1:0]  in_psr,
  input  logic [AW-1:0]    in_r0,
  input  logic [AW-1:0]    in_ttbr,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_write,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    out_pc,
  output logic [AW-1:0]    out_sp,
  output logic [PSRW-1:0]  out_psr,
  output logic [AW-1:0]    out_r0
);
  localparam logic [AW-1:0] FOUR = AW'(4);
  localparam int IMM3_LSB = 5;

  seq_state_e      state_q;
  xfer_kind_e      kind_in;
  xfer_kind_e      kind_q;
  logic            delay_q, wide_q, zero_q;
  logic [AW-1:0]   opnd_q, pc_q, sp_q, r0_q, ttbr_q;
  logic [PSRW-1:0] psr_q;
  logic [DW-1:0]   word0_q, word1_q;
  logic [AW-1:0]   branch_pc, ret_addr;
  logic            accept;
  logic            mem_fire;

  assign kind_in   = xfer_kind_e'(in_kind);
  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign mem_valid = (state_q == ST_ACC0) || (state_q == ST_ACC1);
  assign mem_fire  = mem_valid && mem_ready;
  assign out_valid = (state_q == ST_DONE);

  // sequencing of instruction, memory and result phases
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid)
                   state_q <= (access_count(kind_in) == 2'd0) ? ST_DONE : ST_ACC0;
        ST_ACC0: if (mem_ready)
                   state_q <= (access_count(kind_q) == 2'd2) ? ST_ACC1 : ST_DONE;
        ST_ACC1: if (mem_ready) state_q <= ST_DONE;
        ST_DONE: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // operand capture at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_JEQ_S;
      delay_q <= 1'b0;
      wide_q  <= 1'b0;
      zero_q  <= 1'b0;
      opnd_q  <= '0;
      pc_q    <= '0;
      sp_q    <= '0;
      psr_q   <= '0;
      r0_q    <= '0;
      ttbr_q  <= '0;
    end else if (accept) begin
      kind_q  <= kind_in;
      delay_q <= in_delay;
      wide_q  <= in_wide;
      zero_q  <= in_zero;
      opnd_q  <= in_operand;
      pc_q    <= in_pc;
      sp_q    <= in_sp;
      psr_q   <= in_psr;
      r0_q    <= in_r0;
      ttbr_q  <= in_ttbr;
    end
  end

  // read data capture, one word per access slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word0_q <= '0;
      word1_q <= '0;
    end else if (mem_fire) begin
      if (state_q == ST_ACC0) word0_q <= mem_rdata;
      else                    word1_q <= mem_rdata;
    end
  end

  xfer_target #(.AW(AW)) u_target (
    .kind      (kind_q),
    .delay     (delay_q),
    .wide      (wide_q),
    .zero      (zero_q),
    .operand   (opnd_q),
    .pc        (pc_q),
    .branch_pc (branch_pc),
    .ret_addr  (ret_addr)
  );

  xfer_plan #(.AW(AW), .PSRW(PSRW), .DBG_BASE(DBG_BASE)) u_plan (
    .kind      (kind_q),
    .step      (state_q == ST_ACC1),
    .sp        (sp_q),
    .pc        (pc_q),
    .psr       (psr_q),
    .r0        (r0_q),
    .ttbr      (ttbr_q),
    .ret_addr  (ret_addr),
    .imm5      (opnd_q[4:0]),
    .acc_write (mem_write),
    .acc_addr  (mem_addr),
    .acc_wdata (mem_wdata)
  );

  xfer_result #(.AW(AW), .PSRW(PSRW), .IL_LSB(IL_LSB), .ILW(ILW), .DBG_VEC(DBG_VEC)) u_result (
    .kind      (kind_q),
    .branch_pc (branch_pc),
    .sp        (sp_q),
    .psr       (psr_q),
    .r0        (r0_q),
    .new_level (opnd_q[IMM3_LSB +: ILW]),
    .word0     (word0_q),
    .word1_lo  (word1_q[AW-1:0]),
    .nxt_pc    (out_pc),
    .nxt_sp    (out_sp),
    .nxt_psr   (out_psr),
    .nxt_r0    (out_r0)
  );

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pc) && $stable(out_sp));

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_wdata) && $stable(mem_write));

  // R14
  mem_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !in_ready && !out_valid);

  // R2
  jump_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> access_count(kind_q) != 2'd0);

  // R6
  call_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_call(kind_q) |-> out_sp == sp_q - FOUR);

  // R10
  dbrk_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && kind_q == K_DBRK |-> out_pc == DBG_VEC && out_sp == sp_q);

  // R7
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sp == sp_q) || (out_sp == sp_q - FOUR) || (out_sp == sp_q + FOUR));

endmodule

// File: tb/xfer_seq_test.sv
module xfer_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_kind = '0;
  logic        in_delay = 1'b0, in_wide = 1'b0, in_zero = 1'b0;
  logic [23:0] in_operand = '0, in_pc = '0, in_sp = '0, in_r0 = '0, in_ttbr = '0;
  logic [7:0]  in_psr = '0;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b0;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_pc, out_sp, out_r0;
  logic [7:0]  out_psr;

  localparam logic [23:0] DBASE = 24'hFFF800;
  localparam logic [23:0] DVEC  = 24'hFFFC00;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] mem_model(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a ^ 24'h5A5A5A};
  endfunction

  assign mem_rdata = mem_model(mem_addr);

  xfer_seq uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_delay(in_delay), .in_wide(in_wide), .in_zero(in_zero),
    .in_operand(in_operand), .in_pc(in_pc), .in_sp(in_sp), .in_psr(in_psr),
    .in_r0(in_r0), .in_ttbr(in_ttbr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pc(out_pc), .out_sp(out_sp), .out_psr(out_psr), .out_r0(out_r0)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string kind_tag(input int k);
    case (k)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5, 6: return "R4";
      7, 8, 9: return "R5";
      10:      return "R7";
      11, 12:  return "R8";
      13:      return "R9";
      14:      return "R10";
      default: return "R11";
    endcase
  endfunction

  logic [23:0] e_pc, e_sp, e_r0;
  logic [7:0]  e_psr;
  int          e_n;
  logic        e_we [2];
  logic [23:0] e_ad [2];
  logic [31:0] e_wd [2];

  task automatic run_op(input int k, input bit d, input bit z, input int p,
                        input int stall, input bit hold);
    logic [23:0] pc, sp, op, r0, tb, pc2, ret, s7, s10, dl, va;
    logic [7:0]  psr;
    logic [31:0] w;
    bit          wd;
    string       tg, tsp;
    int          na, left, guard;
    bit          got;
    case (p)
      0:       begin pc = 24'h001000; sp = 24'h008000; op = 24'h00003F; psr = 8'h1F; end
      1:       begin pc = 24'h7FFFF0; sp = 24'h100004; op = 24'hFFFFC0; psr = 8'hE3; end
      2:       begin pc = 24'hFFFFFE; sp = 24'h000002; op = 24'h0A5A45; psr = 8'h5A; end
      default: begin pc = 24'h123456; sp = 24'hFFFFFC; op = 24'h8FF123; psr = 8'hA0; end
    endcase
    wd  = p[0];
    r0  = 24'hABCDEF ^ 24'(p);
    tb  = 24'h00F000;
    pc2 = pc + 24'd2;
    ret = d ? pc + 24'd4 : pc2;
    s7  = {{16{op[6]}}, op[6:0], 1'b0};
    s10 = {{13{op[9]}}, op[9:0], 1'b0};
    dl  = wd ? op : {{4{op[19]}}, op[19:0]};
    e_pc = pc2; e_sp = sp; e_psr = psr; e_r0 = r0; e_n = 0;
    for (int i = 0; i < 2; i++) begin e_we[i] = 0; e_ad[i] = '0; e_wd[i] = '0; end
    case (k)
      0:  if (z)  e_pc = pc2 + s7;
      1:  if (!z) e_pc = pc2 + s7;
      2:  if (z)  e_pc = pc2 + dl;
      3:  if (!z) e_pc = pc2 + dl;
      4:  e_pc = pc2 + op;
      5:  e_pc = pc2 + s10;
      6:  e_pc = pc2 + dl;
      7:  e_pc = op;
      8:  e_pc = {17'd0, op[6:0]};
      9:  e_pc = wd ? op : {4'd0, op[19:0]};
      10: begin e_n = 1; e_ad[0] = sp; w = mem_model(sp); e_pc = w[23:0]; e_sp = sp + 24'd4; end
      11, 12: begin
        e_n = 2; e_we[0] = 1; e_ad[0] = sp - 24'd4; e_wd[0] = {psr, pc2};
        va = tb + {17'd0, op[4:0], 2'b00}; e_ad[1] = va;
        w = mem_model(va); e_pc = w[23:0]; e_sp = sp - 24'd4;
        if (k == 12) e_psr = {op[7:5], psr[4:0]};
      end
      13: begin e_n = 1; e_ad[0] = sp; w = mem_model(sp); e_psr = w[31:24]; e_pc = w[23:0]; e_sp = sp + 24'd4; end
      14: begin
        e_n = 2; e_we[0] = 1; e_ad[0] = DBASE; e_wd[0] = {psr, pc2};
        e_we[1] = 1; e_ad[1] = DBASE + 24'd4; e_wd[1] = {8'h00, r0}; e_pc = DVEC;
      end
      default: begin
        e_n = 2; e_ad[0] = DBASE; e_ad[1] = DBASE + 24'd4;
        w = mem_model(DBASE); e_psr = w[31:24]; e_pc = w[23:0];
        w = mem_model(DBASE + 24'd4); e_r0 = w[23:0];
      end
    endcase
    if (k >= 4 && k <= 9) begin
      e_n = 1; e_we[0] = 1; e_ad[0] = sp - 24'd4; e_wd[0] = {8'h00, ret}; e_sp = sp - 24'd4;
    end
    tg  = (p == 2) ? "R13" : kind_tag(k);
    tsp = (k >= 4 && k <= 9) ? "R6" : tg;

    @(negedge clk);
    chk("R1", "in_ready idle", {31'd0, in_ready}, 32'd1);
    in_kind = 4'(k); in_delay = d; in_wide = wd; in_zero = z; in_operand = op;
    in_pc = pc; in_sp = sp; in_psr = psr; in_r0 = r0; in_ttbr = tb; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "in_ready busy", {31'd0, in_ready}, 32'd0);
    na = 0; left = stall; guard = 0; got = 0;
    while (!got && guard < 60) begin
      guard++;
      if (mem_valid) begin
        if (left > 0) begin
          mem_ready = 1'b0; left--;
        end else begin
          mem_ready = 1'b1;
          if (na < 2) begin
            chk((k >= 4 && k <= 9) ? "R6" : tg, "access dir", {31'd0, mem_write}, {31'd0, e_we[na]});
            chk((k >= 4 && k <= 9) ? "R6" : tg, "access addr", {8'd0, mem_addr}, {8'd0, e_ad[na]});
            if (e_we[na]) chk((k >= 4 && k <= 9) ? "R6" : tg, "write data", mem_wdata, e_wd[na]);
          end
          na++; left = stall;
        end
        @(negedge clk);
      end else begin
        mem_ready = 1'b0;
        if (out_valid) begin
          chk(tg,  "next pc",  {8'd0, out_pc}, {8'd0, e_pc});
          chk(tsp, "next sp",  {8'd0, out_sp}, {8'd0, e_sp});
          chk(tg,  "status",   {24'd0, out_psr}, {24'd0, e_psr});
          chk(tg,  "r0",       {8'd0, out_r0}, {8'd0, e_r0});
          if (hold) begin
            out_ready = 1'b0;
            @(negedge clk);
            chk("R1", "held valid", {31'd0, out_valid}, 32'd1);
            chk("R1", "held pc", {8'd0, out_pc}, {8'd0, e_pc});
          end
          out_ready = 1'b1;
          @(negedge clk);
          out_ready = 1'b0;
          chk("R1", "idle after take", {31'd0, in_ready}, 32'd1);
          got = 1;
        end else begin
          @(negedge clk);
        end
      end
    end
    mem_ready = 1'b0;
    chk((stall > 0) ? "R12" : tg, "access count", 32'(na), 32'(e_n));
    chk(tg, "result seen", {31'd0, got}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R14", "reset in_ready",  {31'd0, in_ready},  32'd1);
    chk("R14", "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R14", "reset mem_valid", {31'd0, mem_valid}, 32'd0);
    rst_n = 1'b1;
    for (int st = 0; st < 3; st++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 16; k++)
          for (int d = 0; d < 2; d++)
            for (int z = 0; z < 2; z++)
              run_op(k, d[0], z[0], p, st, (st == 1));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule